// File: doc/BRIEF.md
# Colour Lookup Table Host-Access Controller

This block owns the node memory of a three-axis colour lookup table with 17 nodes per axis (4913 nodes). Each node stores three 12-bit components. A host reaches the memory through four word-wide registers on a simple register bus. It opens host access, sets a starting node together with a direction flag, and then streams whole nodes into the table or back out of it through a single data register. Each node travels as two consecutive 32-bit words.

While host access is closed, the video path owns the memory. It reads nodes directly through a lookup port by node index. A LUT-enable bit drives a bypass flag so that downstream logic can pass pixels through unchanged. The block does not interpolate between nodes and does not generate table contents.

Top module: `lut3d_host_port`

## Requirements
- R1: After reset, host access is closed, the LUT is disabled, so `lk_bypass` is 1, the node pointer is 0 in write direction, and `bus_rdata` is 0.
- R2: In write direction with host access open, a data-register write (offset 2) with the toggle at first half stores bits 27:16 as component 1 and bits 11:0 as component 2. The next data write supplies component 0 in bits 11:0 and commits the whole node {c0,c1,c2} to the pointed node. Bits outside these fields are ignored.
- R3: A write to the address register (offset 1) loads the node pointer from bits 12:0, takes bit 31 as the direction (0 = stream write, 1 = stream read), and resets the half toggle. A node index above 4912 loads as 0. A read of this register returns the direction in bit 31 and the pointer in bits 12:0, with zeros elsewhere.
- R4: The node pointer advances by one after the second data access of each node. It wraps from 4912 to 0 and never leaves the range 0..4912.
- R5: In read direction with host access open, successive data-register reads return the nodes in ascending order. The first word of a node holds c1 in bits 27:16 and c2 in bits 11:0. The second word holds c0 in bits 11:0. Every other bit reads 0. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R6: While the host-access bit (offset 0, bit 0) is 0, data-register accesses change neither the memory nor the pointer, and data-register reads return 0.
- R7: The lookup port returns the node selected by `lk_node` one cycle after it is presented, as {c0,c1,c2} from MSB to LSB. It returns 0 while host access is open and in the first cycle after host access closes.
- R8: The LUT control register (offset 3) stores the enable bit in bit 0 and a 3-bit extension field in bits 6:4. It reads back these fields with zeros elsewhere. `lk_bypass` is the inverse of the stored enable bit.
- R9: Data-register accesses that do not match the direction are ignored. In read direction, writes neither change memory nor move the pointer. In write direction, reads return 0 and do not move the pointer.
- R10: A first data word that is not followed by its second word commits nothing. Loading the address register discards the staged half, and the node keeps its earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset: 0 access, 1 address, 2 data, 3 LUT control |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| lk_node | input | 13 | Node index requested by the video path |
| lk_data | output | 36 | Node contents {c0,c1,c2} for the video path |
| lk_bypass | output | 1 | High while the LUT is disabled |

## Verification
The checker holds on every cycle that the pointer stays in range and steps correctly after each commit, and that no node is committed while host access is closed. It also holds that the lookup output is silent while the host owns the memory, that the padding bits of node words read back as zero, and that clearing the enable bit raises bypass. Only the bench scenarios can show the packing of the data fields, the order of nodes in read-back, the wrap after a full-table fill, the handling of out-of-range start nodes, the discarding of staged half-nodes, and the silence of mismatched-direction accesses. The bench compares each clock against a behavioural model of the register file and the table.

// File: rtl/lut3d_pkg.sv
package lut3d_pkg;

    typedef enum logic [1:0] {
        SEL_HACC = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_LCTL = 2'd3
    } reg_sel_e;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned MODE_BIT = 31;
    localparam int unsigned HI_LSB   = 16;
    localparam int unsigned EN_BIT   = 0;
    localparam int unsigned EXT_LSB  = 4;
    localparam int unsigned EXT_W    = 3;

endpackage

// File: rtl/lut3d_ctl_regs.sv
module lut3d_ctl_regs
    import lut3d_pkg::*;
#(
    parameter int unsigned XW = EXT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic          wr_hacc,
    input  logic          wr_en_bit,
    input  logic [XW-1:0] wr_ext,
    output logic          hacc_o,
    output logic          lut_en_o,
    output logic [XW-1:0] ext_o
);

    typedef struct packed {
        logic          hacc;
        logic          en;
        logic [XW-1:0] ext;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                SEL_HACC: r_d.hacc = wr_hacc;
                SEL_LCTL: begin
                    r_d.en  = wr_en_bit;
                    r_d.ext = wr_ext;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hacc_o   = r_q.hacc;
    assign lut_en_o = r_q.en;
    assign ext_o    = r_q.ext;

endmodule

// File: rtl/lut3d_stream_ctl.sv
module lut3d_stream_ctl #(
    parameter int unsigned NODES = 4913,
    parameter int unsigned AW    = 13,
    parameter int unsigned CW    = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hacc,
    input  logic            load,
    input  logic            load_mode,
    input  logic [AW-1:0]   load_node,
    input  logic            data_wr,
    input  logic            data_rd,
    input  logic [CW-1:0]   wr_hi,
    input  logic [CW-1:0]   wr_lo,
    output logic [AW-1:0]   ptr_o,
    output logic            mode_o,
    output logic            half_o,
    output logic            commit_o,
    output logic [AW-1:0]   commit_node_o,
    output logic [3*CW-1:0] commit_val_o
);

    localparam logic [AW-1:0] LAST_NODE = AW'(NODES - 1);
    localparam logic [31:0]   NODES_W   = 32'(NODES);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          mode;
        logic          half;
        logic [CW-1:0] stg_hi;
        logic [CW-1:0] stg_lo;
    } strm_t;

    strm_t s_d, s_q;
    logic  step;
    logic  commit;

    always_comb begin
        s_d    = s_q;
        step   = 1'b0;
        commit = 1'b0;
        if (load) begin
            s_d.mode = load_mode;
            s_d.half = 1'b0;
            s_d.ptr  = ((32'(load_node)) < NODES_W) ? load_node : '0;
        end else if (hacc) begin
            if (!s_q.mode && data_wr) begin
                if (!s_q.half) begin
                    s_d.stg_hi = wr_hi;
                    s_d.stg_lo = wr_lo;
                    s_d.half   = 1'b1;
                end else begin
                    commit = 1'b1;
                    step   = 1'b1;
                end
            end else if (s_q.mode && data_rd) begin
                if (s_q.half) begin
                    step = 1'b1;
                end else begin
                    s_d.half = 1'b1;
                end
            end
        end
        if (step) begin
            s_d.half = 1'b0;
            s_d.ptr  = (s_q.ptr == LAST_NODE) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr_o         = s_q.ptr;
    assign mode_o        = s_q.mode;
    assign half_o        = s_q.half;
    assign commit_o      = commit;
    assign commit_node_o = s_q.ptr;
    assign commit_val_o  = {wr_lo, s_q.stg_hi, s_q.stg_lo};

endmodule

// File: rtl/lut3d_node_ram.sv
module lut3d_node_ram #(
    parameter int unsigned DEPTH = 4913,
    parameter int unsigned AW    = 13,
    parameter int unsigned DW    = 36
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end

endmodule

// File: rtl/lut3d_host_port.sv
module lut3d_host_port
    import lut3d_pkg::*;
#(
    parameter int unsigned AXIS = 17,
    parameter int unsigned CW   = 12,
    parameter int unsigned AW   = $clog2(AXIS * AXIS * AXIS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    input  logic            bus_we,
    input  logic            bus_re,
    output logic [31:0]     bus_rdata,
    input  logic [AW-1:0]   lk_node,
    output logic [3*CW-1:0] lk_data,
    output logic            lk_bypass
);

    localparam int unsigned NODES = AXIS * AXIS * AXIS;
    localparam int unsigned NW    = 3 * CW;

    reg_sel_e          sel;
    logic              hacc_q;
    logic              lut_en_q;
    logic [EXT_W-1:0]  ext_q;
    logic [AW-1:0]     ptr_q;
    logic              mode_q;
    logic              half_q;
    logic              commit;
    logic [AW-1:0]     commit_node;
    logic [NW-1:0]     commit_val;
    logic [AW-1:0]     ram_raddr;
    logic [NW-1:0]     ram_q;
    logic              unused_wdata;

    assign sel          = reg_sel_e'(bus_addr);
    assign unused_wdata = ^bus_wdata;

    lut3d_ctl_regs #(.XW(EXT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .sel       (sel),
        .wr_hacc   (bus_wdata[0]),
        .wr_en_bit (bus_wdata[EN_BIT]),
        .wr_ext    (bus_wdata[EXT_LSB +: EXT_W]),
        .hacc_o    (hacc_q),
        .lut_en_o  (lut_en_q),
        .ext_o     (ext_q)
    );

    lut3d_stream_ctl #(.NODES(NODES), .AW(AW), .CW(CW)) u_strm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hacc          (hacc_q),
        .load          (bus_we && (sel == SEL_ADDR)),
        .load_mode     (bus_wdata[MODE_BIT]),
        .load_node     (bus_wdata[AW-1:0]),
        .data_wr       (bus_we && (sel == SEL_DATA)),
        .data_rd       (bus_re && (sel == SEL_DATA)),
        .wr_hi         (bus_wdata[HI_LSB +: CW]),
        .wr_lo         (bus_wdata[CW-1:0]),
        .ptr_o         (ptr_q),
        .mode_o        (mode_q),
        .half_o        (half_q),
        .commit_o      (commit),
        .commit_node_o (commit_node),
        .commit_val_o  (commit_val)
    );

    assign ram_raddr = hacc_q ? ptr_q : lk_node;

    lut3d_node_ram #(.DEPTH(NODES), .AW(AW), .DW(NW)) u_ram (
        .clk   (clk),
        .we    (commit),
        .waddr (commit_node),
        .wdata (commit_val),
        .raddr (ram_raddr),
        .rdata (ram_q)
    );

    typedef struct packed {
        logic [WORD_W-1:0] rd_word;
        logic              rd_node;
        logic              rd_half;
        logic              hacc_dly;
    } outp_t;

    outp_t o_d, o_q;

    always_comb begin
        o_d          = '0;
        o_d.rd_half  = half_q;
        o_d.hacc_dly = hacc_q;
        if (bus_re) begin
            case (sel)
                SEL_HACC: o_d.rd_word[0] = hacc_q;
                SEL_ADDR: begin
                    o_d.rd_word[AW-1:0]   = ptr_q;
                    o_d.rd_word[MODE_BIT] = mode_q;
                end
                SEL_LCTL: begin
                    o_d.rd_word[EN_BIT]              = lut_en_q;
                    o_d.rd_word[EXT_LSB +: EXT_W]    = ext_q;
                end
                SEL_DATA: o_d.rd_node = hacc_q && mode_q;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    logic [WORD_W-1:0] node_word;

    always_comb begin
        node_word = '0;
        if (o_q.rd_half) begin
            node_word[CW-1:0] = ram_q[NW-1 -: CW];
        end else begin
            node_word[HI_LSB +: CW] = ram_q[2*CW-1 -: CW];
            node_word[CW-1:0]       = ram_q[CW-1:0];
        end
    end

    assign bus_rdata = o_q.rd_node ? node_word : o_q.rd_word;
    assign lk_data   = (hacc_q || o_q.hacc_dly) ? '0 : ram_q;
    assign lk_bypass = !lut_en_q;

endmodule

// File: rtl/lut3d_host_port_chk.sv
module lut3d_host_port_chk #(
    parameter int unsigned NODES = 4913,
    parameter int unsigned AW    = 13,
    parameter int unsigned CW    = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      bus_addr,
    input logic            bus_we,
    input logic            bus_re,
    input logic            wr_bit0,
    input logic [31:0]     bus_rdata,
    input logic [3*CW-1:0] lk_data,
    input logic            lk_bypass,
    input logic            hacc,
    input logic [AW-1:0]   ptr,
    input logic            commit
);

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) < 32'(NODES)); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (ptr == (($past(ptr) == AW'(NODES - 1)) ? '0 : $past(ptr) + 1'b1))); // R4

    AST_NO_COMMIT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !hacc |-> !commit); // R6

    AST_LOOKUP_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        hacc |-> (lk_data == '0)); // R7

    AST_BYPASS_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == 2'd3) && !wr_bit0) |=> lk_bypass); // R8

    AST_RDATA_PADDING: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (bus_addr == 2'd2)) |=>
        (((bus_rdata >> (16 + CW)) == 32'd0) && ((bus_rdata[15:0] >> CW) == 16'd0))); // R5

endmodule

bind lut3d_host_port lut3d_host_port_chk #(.NODES(NODES), .AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .wr_bit0   (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .lk_data   (lk_data),
    .lk_bypass (lk_bypass),
    .hacc      (hacc_q),
    .ptr       (ptr_q),
    .commit    (commit)
);

// File: tb/tb_lut3d_host_port.sv
module tb_lut3d_host_port;

    localparam int NODES = 4913;
    localparam int AW    = 13;
    localparam int CW    = 12;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      bus_addr;
    logic [31:0]     bus_wdata;
    logic            bus_we;
    logic            bus_re;
    logic [31:0]     bus_rdata;
    logic [AW-1:0]   lk_node;
    logic [3*CW-1:0] lk_data;
    logic            lk_bypass;

    always #5 clk = ~clk;

    lut3d_host_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .lk_node(lk_node), .lk_data(lk_data), .lk_bypass(lk_bypass)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string req      = "R1";
    int    lk_drive = 0;
    bit    done     = 0;

    // behavioural model
    int m_c0 [NODES];
    int m_c1 [NODES];
    int m_c2 [NODES];
    bit m_ok [NODES];
    int m_ptr, m_ext, m_st_hi, m_st_lo;
    bit m_mode, m_half, m_hacc, m_en;
    logic [31:0]     e_rdata;
    logic [3*CW-1:0] e_lk;
    bit e_rd_known, e_lk_known;

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_step(logic [1:0] a, logic [31:0] wd, bit we, bit re, int lk);
        bit old_hacc = m_hacc;
        e_rd_known = 1;
        e_rdata    = '0;
        if (re) begin
            case (a)
                2'd0: e_rdata = {31'b0, m_hacc};
                2'd1: e_rdata = {m_mode, 18'b0, 13'(m_ptr)};
                2'd3: e_rdata = {25'b0, 3'(m_ext), 3'b0, m_en};
                default: if (m_hacc && m_mode) begin
                    e_rd_known = m_ok[m_ptr];
                    if (m_half) e_rdata = {20'b0, 12'(m_c0[m_ptr])};
                    else        e_rdata = {4'b0, 12'(m_c1[m_ptr]), 4'b0, 12'(m_c2[m_ptr])};
                end
            endcase
        end
        e_lk_known = !old_hacc && m_ok[lk];
        e_lk = {12'(m_c0[lk]), 12'(m_c1[lk]), 12'(m_c2[lk])};
        if (we) begin
            case (a)
                2'd0: m_hacc = wd[0];
                2'd1: begin
                    m_mode = wd[31];
                    m_ptr  = (int'(wd[12:0]) < NODES) ? int'(wd[12:0]) : 0;
                    m_half = 0;
                end
                2'd3: begin m_en = wd[0]; m_ext = int'(wd[6:4]); end
                default: if (old_hacc && !m_mode) begin
                    if (!m_half) begin
                        m_st_hi = int'(wd[27:16]); m_st_lo = int'(wd[11:0]); m_half = 1;
                    end else begin
                        m_c0[m_ptr] = int'(wd[11:0]); m_c1[m_ptr] = m_st_hi;
                        m_c2[m_ptr] = m_st_lo; m_ok[m_ptr] = 1;
                        m_half = 0; m_ptr = (m_ptr == NODES-1) ? 0 : m_ptr + 1;
                    end
                end
            endcase
        end
        if (re && a == 2'd2 && old_hacc && m_mode) begin
            if (m_half) begin
                m_half = 0; m_ptr = (m_ptr == NODES-1) ? 0 : m_ptr + 1;
            end else m_half = 1;
        end
        if (old_hacc || m_hacc) begin
            e_lk = '0; e_lk_known = 1;
        end
    endtask

    task automatic cyc(logic [1:0] a, logic [31:0] wd, bit we, bit re);
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_we = we; bus_re = re;
        lk_node = AW'(lk_drive);
        @(posedge clk);
        model_step(a, wd, we, re, lk_drive);
        #2;
        if (e_rd_known) check("bus_rdata", 64'(bus_rdata), 64'(e_rdata));
        if (e_lk_known) check("lk_data", 64'(lk_data), 64'(e_lk));
        check("lk_bypass", 64'(lk_bypass), 64'(!m_en));
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d); cyc(a, d, 1, 0); endtask
    task automatic rd(logic [1:0] a); cyc(a, '0, 0, 1); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) cyc(2'd0, '0, 0, 0); endtask

    task automatic put_node(int c0, int c1, int c2);
        // garbage placed in bits that must be ignored (R2)
        wr(2'd2, {4'hA, 12'(c1), 4'h5, 12'(c2)});
        wr(2'd2, {20'hFFFFF, 12'(c0)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_we = 0; bus_re = 0; lk_node = 0;
        m_ptr = 0; m_ext = 0; m_st_hi = 0; m_st_lo = 0;
        m_mode = 0; m_half = 0; m_hacc = 0; m_en = 0;
        for (int i = 0; i < NODES; i++) begin m_ok[i] = 0; m_c0[i] = 0; m_c1[i] = 0; m_c2[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        req = "R1"; idle(2); rd(2'd0); rd(2'd1); rd(2'd3); idle(1);

        req = "R8"; wr(2'd3, 32'hFFFF_FF72); rd(2'd3); wr(2'd3, 32'h0000_0051); rd(2'd3);

        req = "R6"; wr(2'd1, 32'd5); put_node(1, 2, 3); rd(2'd1); rd(2'd2); idle(1);

        req = "R2"; wr(2'd0, 32'd1); wr(2'd1, 32'd0);
        for (int i = 0; i < 10; i++) put_node(100 + i, 2000 + i * 3, 4095 - i);
        rd(2'd1);

        req = "R3"; wr(2'd1, 32'h8000_0003); rd(2'd1); wr(2'd1, 32'd5000); rd(2'd1);
        wr(2'd1, 32'h0000_1FFF); rd(2'd1);

        req = "R5"; wr(2'd1, 32'h8000_0000);
        for (int i = 0; i < 20; i++) rd(2'd2);
        rd(2'd1);

        req = "R9"; wr(2'd1, 32'h8000_0002); put_node(7, 7, 7); rd(2'd1); rd(2'd2); rd(2'd2);
        wr(2'd1, 32'd4); rd(2'd2); rd(2'd1);

        req = "R10"; wr(2'd1, 32'd7); wr(2'd2, 32'h0ABC_0DEF); wr(2'd1, 32'h8000_0007);
        rd(2'd2); rd(2'd2); rd(2'd1);

        req = "R4"; wr(2'd1, 32'd4911);
        put_node(11, 22, 33); put_node(44, 55, 66); put_node(77, 88, 99); rd(2'd1);
        wr(2'd1, 32'h8000_0000 | 32'd4911);
        for (int i = 0; i < 6; i++) rd(2'd2);
        rd(2'd1);

        req = "R4"; wr(2'd1, 32'd0);
        for (int i = 0; i < NODES; i++) put_node((i * 7) & 4095, (i * 13 + 5) & 4095, (i * 3 + 1000) & 4095);
        rd(2'd1);
        req = "R5"; wr(2'd1, 32'h8000_0000);
        for (int i = 0; i < 2 * NODES; i++) rd(2'd2);
        rd(2'd1);

        req = "R7"; lk_drive = 17; wr(2'd0, 32'd0);
        for (int i = 0; i < 40; i++) begin
            lk_drive = (i == 5) ? NODES - 1 : (i == 6) ? 0 : (i * 397) % NODES;
            idle(1);
        end
        lk_drive = 100; wr(2'd0, 32'd1); idle(3);
        wr(2'd0, 32'd0); idle(3);

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule